// File: doc/BRIEF.md
# Weighted Noise Stream Generator

This block produces single-bit pseudo-random streams whose probability of being 1 is fixed by construction. They serve as noise and as selection signals inside a self-test pattern source. A register of cells updated under a mixed rule-90/rule-150 cellular-automaton law supplies the random bits. Plain AND and OR gates on pairs of those cells set the weights. One stream taps a single cell for weight one half. A second ANDs two cells for weight one quarter. A third, present when a parameter enables it, ORs two cells for weight three quarters.

The register moves one step only on cycles where enable is high. A load strobe replaces its contents with a seed. A zero seed is swapped for a fixed nonzero constant, so the register can never sit in the all-zero state, which would freeze it. All three outputs come from flip-flops and change only on cycles where the register advances.

Top module: `noise_stream_gen`

## Requirements
- R1: After reset is released, all three outputs are 0 and the register holds RESET_SEED (default 16'hACE1). The first enabled cycle then presents taps taken from that value.
- R2: In a cycle with enable low and load low, the register and all three outputs keep their values.
- R3: On an enabled step, cell i becomes cell(i-1) XOR cell(i+1), further XORed with cell i when bit i of RULE is 1 (rule 150) and not XORed with it when that bit is 0 (rule 90). Cells beyond either end read as 0. Default RULE is 16'hEB2D.
- R4: On an enabled step, half_o takes the value of cell TAP_H (default 7) of the register as it was before that step.
- R5: On an enabled step, quarter_o takes the AND of cells TAP_QA and TAP_QB (defaults 2 and 11) of the register before that step.
- R6: On an enabled step with HAS_3Q set, three_q_o takes the OR of cells TAP_TA and TAP_TB (defaults 5 and 13) of the register before that step. With HAS_3Q clear, three_q_o is constantly 0.
- R7: A cycle with load high writes a nonzero seed into the register and leaves the outputs unchanged. Load wins over enable in the same cycle.
- R8: A load with seed equal to zero writes ZERO_SUB (default 16'h8001) instead, and the register is never all-zero.
- R9: Over a long enabled run, the fractions of ones on half_o, quarter_o and three_q_o stay close to 0.5, 0.25 and 0.75.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Advance the register one step |
| load | input | 1 | Replace the register with the seed |
| seed | input | W | Seed value; zero is substituted |
| half_o | output | 1 | Stream with weight 0.5 |
| quarter_o | output | 1 | Stream with weight 0.25 |
| three_q_o | output | 1 | Stream with weight 0.75 (0 when HAS_3Q is clear) |

## Verification
The hardest cases to reach from the ports are the ones where the register state is hidden: a zero-seed load, and a load that coincides with enable. The stimulus loads a zero seed, or raises load and enable together, and then runs several enabled steps. The bench keeps its own model of the cell law, so the substituted value or the priority shows up in the stream contents that follow. The weight requirement needs a run of thousands of steps, and the bench counts ones on each output over that run.

// File: rtl/noise_stream_gen.sv
module noise_stream_gen #(
  parameter int          W          = 16,
  parameter logic [W-1:0] RULE       = 16'hEB2D,
  parameter logic [W-1:0] RESET_SEED = 16'hACE1,
  parameter logic [W-1:0] ZERO_SUB   = 16'h8001,
  parameter int          TAP_H      = 7,
  parameter int          TAP_QA     = 2,
  parameter int          TAP_QB     = 11,
  parameter int          TAP_TA     = 5,
  parameter int          TAP_TB     = 13,
  parameter bit          HAS_3Q     = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         load,
  input  logic [W-1:0] seed,
  output logic         half_o,
  output logic         quarter_o,
  output logic         three_q_o
);

  logic [W-1:0] state;
  logic [W-1:0] nxt_state;
  logic [W+1:0] padded;
  logic [W-1:0] load_val;

  assign padded   = {1'b0, state, 1'b0};
  assign load_val = (seed == '0) ? ZERO_SUB : seed;

  always_comb begin
    for (int i = 0; i < W; i++)
      nxt_state[i] = padded[i] ^ padded[i+2] ^ (RULE[i] & state[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= RESET_SEED;
    else if (load) state <= load_val;
    else if (en)   state <= nxt_state;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_o    <= 1'b0;
      quarter_o <= 1'b0;
    end else if (en && !load) begin
      half_o    <= state[TAP_H];
      quarter_o <= state[TAP_QA] & state[TAP_QB];
    end
  end

  generate
    if (HAS_3Q) begin : g_3q
      always_ff @(posedge clk) begin
        if (!rst_n)            three_q_o <= 1'b0;
        else if (en && !load)  three_q_o <= state[TAP_TA] | state[TAP_TB];
      end
    end else begin : g_no3q
      assign three_q_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/noise_stream_chk.sv
module noise_stream_chk #(
  parameter int          W        = 16,
  parameter logic [W-1:0] ZERO_SUB = 16'h8001,
  parameter int          TAP_QA   = 2,
  parameter int          TAP_QB   = 11,
  parameter int          TAP_TA   = 5,
  parameter int          TAP_TB   = 13,
  parameter bit          HAS_3Q   = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         load,
  input logic [W-1:0] seed,
  input logic [W-1:0] state,
  input logic         half_o,
  input logic         quarter_o,
  input logic         three_q_o
);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> ($stable(state) && $stable(half_o) && $stable(quarter_o) && $stable(three_q_o)));

  // R7
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && seed != '0) |=> (state == $past(seed) && $stable(half_o) && $stable(quarter_o)));

  // R8
  zero_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && seed == '0) |=> (state == ZERO_SUB));

  // R8
  never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);

  // R5
  quarter_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load) |=> (quarter_o == ($past(state[TAP_QA]) & $past(state[TAP_QB]))));

  // R6
  three_q_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && HAS_3Q) |=> (three_q_o == ($past(state[TAP_TA]) | $past(state[TAP_TB]))));

endmodule

bind noise_stream_gen noise_stream_chk #(
  .W(W), .ZERO_SUB(ZERO_SUB), .TAP_QA(TAP_QA), .TAP_QB(TAP_QB),
  .TAP_TA(TAP_TA), .TAP_TB(TAP_TB), .HAS_3Q(HAS_3Q)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .load(load), .seed(seed), .state(state),
  .half_o(half_o), .quarter_o(quarter_o), .three_q_o(three_q_o)
);

// File: tb/test_noise_stream_gen.sv
module test_noise_stream_gen;
  localparam int W = 16;
  localparam logic [W-1:0] RULE = 16'hEB2D;
  localparam logic [W-1:0] RSEED = 16'hACE1;
  localparam logic [W-1:0] ZSUB = 16'h8001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic load = 1'b0;
  logic [W-1:0] seed = '0;
  logic half_o, quarter_o, three_q_o;

  int nvec = 0;
  int nerr = 0;
  bit finished = 0;

  logic [W-1:0] ms;
  logic [2:0] mo;

  always #10 clk = ~clk;

  noise_stream_gen i_noise_stream_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .load(load), .seed(seed),
    .half_o(half_o), .quarter_o(quarter_o), .three_q_o(three_q_o)
  );

  function automatic logic [W-1:0] step_ca(logic [W-1:0] s);
    logic [W-1:0] n;
    for (int i = 0; i < W; i++) begin
      logic l, r;
      l = (i > 0) ? s[i-1] : 1'b0;
      r = (i < W-1) ? s[i+1] : 1'b0;
      n[i] = l ^ r ^ (RULE[i] ? s[i] : 1'b0);
    end
    return n;
  endfunction

  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: outputs {3q,q,h} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(logic e, logic ld, logic [W-1:0] sd, string req);
    en = e; load = ld; seed = sd;
    @(posedge clk);
    if (ld) ms = (sd == '0) ? ZSUB : sd;
    else if (e) begin
      mo = {ms[5] | ms[13], ms[2] & ms[11], ms[7]};
      ms = step_ca(ms);
    end
    @(negedge clk);
    check(req, {three_q_o, quarter_o, half_o}, mo);
  endtask

  task automatic t_reset();
    rst_n = 0; en = 1; load = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    ms = RSEED; mo = 3'b000;
    check("R1", {three_q_o, quarter_o, half_o}, 3'b000);
    for (int k = 0; k < 6; k++) cyc(1, 0, '0, "R1");
  endtask

  task automatic t_hold();
    for (int k = 0; k < 5; k++) cyc(0, 0, 16'h1234, "R2");
    for (int k = 0; k < 8; k++) cyc(1, 0, '0, "R2");
  endtask

  task automatic t_rule();
    cyc(0, 1, 16'h0001, "R7");
    for (int k = 0; k < 40; k++) cyc(1, 0, '0, "R3");
    cyc(0, 1, 16'h8000, "R7");
    for (int k = 0; k < 40; k++) cyc(1, 0, '0, "R4");
    cyc(1, 1, 16'hFFFF, "R7");
    for (int k = 0; k < 20; k++) cyc(1, 0, '0, "R5");
    cyc(1, 1, 16'h0F0F, "R7");
    for (int k = 0; k < 20; k++) cyc(k[0], 0, '0, "R6");
  endtask

  task automatic t_zero_seed();
    cyc(1, 1, '0, "R8");
    for (int k = 0; k < 30; k++) cyc(1, 0, '0, "R8");
    cyc(0, 1, '0, "R8");
    cyc(0, 0, '0, "R8");
    for (int k = 0; k < 10; k++) cyc(1, 0, '0, "R8");
  endtask

  task automatic t_weights();
    int ch = 0, cq = 0, ct = 0;
    cyc(0, 1, 16'h5A3C, "R7");
    for (int k = 0; k < 4000; k++) begin
      cyc(1, 0, '0, "R9");
      ch += half_o; cq += quarter_o; ct += three_q_o;
    end
    nvec++;
    if (ch < 1800 || ch > 2200) begin nerr++; $display("FAIL R9: half ones actual %0d expected 1800..2200", ch); end
    nvec++;
    if (cq < 800 || cq > 1200) begin nerr++; $display("FAIL R9: quarter ones actual %0d expected 800..1200", cq); end
    nvec++;
    if (ct < 2800 || ct > 3200) begin nerr++; $display("FAIL R9: three-quarter ones actual %0d expected 2800..3200", ct); end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_hold();
    t_rule();
    t_zero_seed();
    t_weights();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nvec++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule